// File: doc/BRIEF.md
# Exception Mask Priority Boosting Unit

This unit keeps three masking controls that software uses to hold off exceptions: a single global bit that shuts out every exception with a configurable level, a fault bit that also shuts out the hard-fault level, and a base-level threshold that shuts out only exceptions at or below a chosen urgency. It merges these with the level of the exception handler that is running now. The result is the effective execution level. A lower number means more urgent, so levels are signed: the fixed levels of reset, NMI and hard fault are negative.

The effective level is combinational from the stored controls and the incoming active level. A pending exception is described by a kind and a configurable level. The unit raises a preempt flag when that exception is more urgent than the effective level. Software changes the controls through a register write port and through set and clear pulses, and every change needs the privilege flag. The fault bit obeys two more rules. It can only be set while the effective level is zero or above. An exception return clears it unless the return is from NMI.

Top module: `excmask_boost`

## Requirements
- R1: After reset, the global bit, the fault bit and the base threshold read 0, and the effective level equals `act_prio`.
- R2: While the global bit is 1, the effective level is at most 0.
- R3: While the fault bit is 1, the effective level is at most -1. A request to set the fault bit by pulse or by write is ignored unless `priv` is 1 and the effective level in that cycle is 0 or greater.
- R4: An exception return with `ret_nmi`=0 clears the fault bit. This takes precedence over any write or pulse in the same cycle. A return with `ret_nmi`=1 does not touch the fault bit.
- R5: A base threshold of 0 has no effect. A nonzero threshold B makes the effective level min(level otherwise in force, B), with B taken as an unsigned value.
- R6: The base threshold stores only its upper PRIO_BITS bits. Written lower bits are dropped and read back as 0 (mask 0xE0 with the default parameters).
- R7: When `priv` is 0, writes and set/clear pulses leave all three controls unchanged.
- R8: `preempt_ok` is 1 exactly when the pending level is strictly less (signed) than the effective level.
- R9: The pending level depends on `pend_kind`: 0 gives `pend_prio` as an unsigned configurable level, 1 gives hard fault (-1), 2 gives NMI (-2) and 3 gives reset (-3).
- R10: `rd_data` is combinational from `rd_sel`: 0 gives the global bit in bit 0, 1 gives the fault bit in bit 0, 2 gives the base threshold, and 3 gives zero.
- R11: `wr_sel` uses the same codes as R10, and the masks take `wr_data[0]`. For one control in the same cycle, a privileged write takes precedence over pulses, and a clear pulse takes precedence over a set pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 1 | Requester is privileged |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for write |
| wr_data | input | FIELD_W | Write data |
| rd_sel | input | 2 | Register selected for read |
| rd_data | output | FIELD_W | Read data |
| gm_set | input | 1 | Set pulse, global bit |
| gm_clr | input | 1 | Clear pulse, global bit |
| fm_set | input | 1 | Set pulse, fault bit |
| fm_clr | input | 1 | Clear pulse, fault bit |
| exc_ret | input | 1 | Exception return pulse |
| ret_nmi | input | 1 | The return is from NMI |
| act_prio | input | FIELD_W+2 | Signed level of the active handler (2^FIELD_W when idle) |
| pend_kind | input | 2 | Kind of the pending exception |
| pend_prio | input | FIELD_W | Configurable level of the pending exception |
| eff_prio | output | FIELD_W+2 | Signed effective execution level |
| preempt_ok | output | 1 | Pending exception may preempt |

## Verification
Three events can compete for the fault bit in one cycle: an exception return, a set or clear from a pulse or a write, and the privilege check. The bench drives exception returns and set pulses in the same cycle, both from NMI and from other handlers. It also drives set requests while an NMI or hard-fault level is active, so that the guard that blocks the set is the one under test. The bench model applies the order return, then write, then clear, then set. The fault bit, the effective level and the preempt flag are compared against that model every cycle.

// File: rtl/excmask_pkg.sv
package excmask_pkg;

  typedef enum logic [1:0] {
    KIND_CFG = 2'd0,
    KIND_HF  = 2'd1,
    KIND_NMI = 2'd2,
    KIND_RST = 2'd3
  } pend_kind_e;

  typedef enum logic [1:0] {
    SEL_GMASK = 2'd0,
    SEL_FMASK = 2'd1,
    SEL_BASE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Fixed urgent levels, signed.
  localparam int LVL_HF  = -1;
  localparam int LVL_NMI = -2;
  localparam int LVL_RST = -3;

  // The more urgent (numerically smaller) of two levels.
  function automatic int more_urgent(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // Level of a pending exception from its kind.
  function automatic int kind_level(pend_kind_e k, int cfg);
    case (k)
      KIND_HF:  return LVL_HF;
      KIND_NMI: return LVL_NMI;
      KIND_RST: return LVL_RST;
      default:  return cfg;
    endcase
  endfunction

endpackage

// File: rtl/excmask_regs.sv
module excmask_regs
  import excmask_pkg::*;
#(
  parameter int FIELD_W   = 8,
  parameter int PRIO_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               gm_set,
  input  logic               gm_clr,
  input  logic               fm_set,
  input  logic               fm_clr,
  input  logic               exc_ret,
  input  logic               ret_nmi,
  input  logic               fm_allow,
  output logic               gmask_q,
  output logic               fmask_q,
  output logic [FIELD_W-1:0] base_q
);

  localparam int LOW_W = FIELD_W - PRIO_BITS;
  localparam logic [FIELD_W-1:0] BASE_KEEP = {{PRIO_BITS{1'b1}}, {LOW_W{1'b0}}};

  logic wr_gm, wr_fm, wr_base, ret_clear;
  logic gm_d, fm_d;

  assign wr_gm     = priv && wr_en && (reg_sel_e'(wr_sel) == SEL_GMASK);
  assign wr_fm     = priv && wr_en && (reg_sel_e'(wr_sel) == SEL_FMASK);
  assign wr_base   = priv && wr_en && (reg_sel_e'(wr_sel) == SEL_BASE);
  assign ret_clear = exc_ret && !ret_nmi;

  always_comb begin
    gm_d = gmask_q;
    if (wr_gm)                gm_d = wr_data[0];
    else if (priv && gm_clr)  gm_d = 1'b0;
    else if (priv && gm_set)  gm_d = 1'b1;
  end

  always_comb begin
    fm_d = fmask_q;
    if (ret_clear)                       fm_d = 1'b0;
    else if (wr_fm) begin
      if (!wr_data[0])                   fm_d = 1'b0;
      else if (fm_allow)                 fm_d = 1'b1;
    end
    else if (priv && fm_clr)             fm_d = 1'b0;
    else if (priv && fm_set && fm_allow) fm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q <= 1'b0;
      fmask_q <= 1'b0;
      base_q  <= '0;
    end else begin
      gmask_q <= gm_d;
      fmask_q <= fm_d;
      if (wr_base) base_q <= wr_data & BASE_KEEP;
    end
  end

endmodule

// File: rtl/excmask_resolve.sv
module excmask_resolve
  import excmask_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int EP_W    = FIELD_W + 2
) (
  input  logic signed [EP_W-1:0] act_prio,
  input  logic                   gmask,
  input  logic                   fmask,
  input  logic [FIELD_W-1:0]     base,
  output logic signed [EP_W-1:0] eff_prio
);

  int lvl;

  always_comb begin
    lvl = int'(act_prio);
    if (base != '0) lvl = more_urgent(lvl, int'({1'b0, base}));
    if (gmask)      lvl = more_urgent(lvl, 0);
    if (fmask)      lvl = more_urgent(lvl, LVL_HF);
    eff_prio = EP_W'(lvl);
  end

endmodule

// File: rtl/excmask_judge.sv
module excmask_judge
  import excmask_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int EP_W    = FIELD_W + 2
) (
  input  logic [1:0]             pend_kind,
  input  logic [FIELD_W-1:0]     pend_prio,
  input  logic signed [EP_W-1:0] eff_prio,
  output logic signed [EP_W-1:0] pend_level,
  output logic                   preempt_ok
);

  assign pend_level = EP_W'(kind_level(pend_kind_e'(pend_kind), int'({1'b0, pend_prio})));
  assign preempt_ok = pend_level < eff_prio;

endmodule

// File: rtl/excmask_boost.sv
module excmask_boost
  import excmask_pkg::*;
#(
  parameter  int FIELD_W   = 8,
  parameter  int PRIO_BITS = 3,
  localparam int EP_W      = FIELD_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   priv,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [FIELD_W-1:0]     wr_data,
  input  logic [1:0]             rd_sel,
  output logic [FIELD_W-1:0]     rd_data,
  input  logic                   gm_set,
  input  logic                   gm_clr,
  input  logic                   fm_set,
  input  logic                   fm_clr,
  input  logic                   exc_ret,
  input  logic                   ret_nmi,
  input  logic signed [EP_W-1:0] act_prio,
  input  logic [1:0]             pend_kind,
  input  logic [FIELD_W-1:0]     pend_prio,
  output logic signed [EP_W-1:0] eff_prio,
  output logic                   preempt_ok
);

  logic               gmask_q, fmask_q, fm_allow;
  logic [FIELD_W-1:0] base_q;
  logic signed [EP_W-1:0] pend_level;

  // Fault bit may be set only while the effective level is 0 or above.
  assign fm_allow = ~eff_prio[EP_W-1];

  excmask_regs #(.FIELD_W(FIELD_W), .PRIO_BITS(PRIO_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .priv(priv), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .gm_set(gm_set), .gm_clr(gm_clr), .fm_set(fm_set),
    .fm_clr(fm_clr), .exc_ret(exc_ret), .ret_nmi(ret_nmi), .fm_allow(fm_allow),
    .gmask_q(gmask_q), .fmask_q(fmask_q), .base_q(base_q)
  );

  excmask_resolve #(.FIELD_W(FIELD_W), .EP_W(EP_W)) u_resolve (
    .act_prio(act_prio), .gmask(gmask_q), .fmask(fmask_q), .base(base_q),
    .eff_prio(eff_prio)
  );

  excmask_judge #(.FIELD_W(FIELD_W), .EP_W(EP_W)) u_judge (
    .pend_kind(pend_kind), .pend_prio(pend_prio), .eff_prio(eff_prio),
    .pend_level(pend_level), .preempt_ok(preempt_ok)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_GMASK: rd_data = FIELD_W'(gmask_q);
      SEL_FMASK: rd_data = FIELD_W'(fmask_q);
      SEL_BASE:  rd_data = base_q;
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/excmask_boost_chk.sv
module excmask_boost_chk #(
  parameter int FIELD_W   = 8,
  parameter int PRIO_BITS = 3,
  parameter int EP_W      = FIELD_W + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   priv,
  input logic                   exc_ret,
  input logic                   ret_nmi,
  input logic                   fm_allow,
  input logic                   gmask_q,
  input logic                   fmask_q,
  input logic [FIELD_W-1:0]     base_q,
  input logic signed [EP_W-1:0] eff_prio,
  input logic signed [EP_W-1:0] pend_level,
  input logic                   preempt_ok
);

  localparam int LOW_W = FIELD_W - PRIO_BITS;

  // R4
  fm_ret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret && !ret_nmi |=> !fmask_q);

  // R4
  fm_nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret && ret_nmi && !priv |=> $stable(fmask_q));

  // R3
  fm_rise_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmask_q) |-> $past(priv) && $past(fm_allow));

  // R3
  fm_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmask_q |-> eff_prio <= -1);

  // R2
  gm_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_q |-> eff_prio <= 0);

  // R7
  unpriv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |=> $stable(gmask_q) && $stable(base_q));

  // R6
  base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[LOW_W-1:0] == '0);

  // R8
  preempt_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_ok && fmask_q |-> pend_level <= -2);

endmodule

bind excmask_boost excmask_boost_chk #(
  .FIELD_W(FIELD_W), .PRIO_BITS(PRIO_BITS), .EP_W(EP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .exc_ret(exc_ret), .ret_nmi(ret_nmi),
  .fm_allow(fm_allow), .gmask_q(gmask_q), .fmask_q(fmask_q), .base_q(base_q),
  .eff_prio(eff_prio), .pend_level(pend_level), .preempt_ok(preempt_ok)
);

// File: tb/excmask_boost_test.sv
`timescale 1ns/1ps
module excmask_boost_test;

  localparam int FW   = 8;
  localparam int PB   = 3;
  localparam int EPW  = FW + 2;
  localparam int IDLE = 1 << FW;
  localparam int BMASK = ((1 << FW) - 1) ^ ((1 << (FW - PB)) - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic priv = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [FW-1:0] wr_data = '0, pend_prio = '0;
  logic gm_set = 1'b0, gm_clr = 1'b0, fm_set = 1'b0, fm_clr = 1'b0;
  logic exc_ret = 1'b0, ret_nmi = 1'b0;
  logic signed [EPW-1:0] act_prio = EPW'(IDLE);
  logic [1:0] pend_kind = 2'd0;
  logic [FW-1:0] rd_data;
  logic signed [EPW-1:0] eff_prio;
  logic preempt_ok;

  int tests = 0, fails = 0;
  int m_gm = 0, m_fm = 0, m_base = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  excmask_boost #(.FIELD_W(FW), .PRIO_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .priv(priv), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .gm_set(gm_set),
    .gm_clr(gm_clr), .fm_set(fm_set), .fm_clr(fm_clr), .exc_ret(exc_ret),
    .ret_nmi(ret_nmi), .act_prio(act_prio), .pend_kind(pend_kind),
    .pend_prio(pend_prio), .eff_prio(eff_prio), .preempt_ok(preempt_ok)
  );

  // Reference: effective level as the minimum of the contributors in force.
  function automatic int exp_eff();
    int e = int'(act_prio);
    if (m_base != 0 && m_base < e) e = m_base;
    if (m_gm != 0 && e > 0) e = 0;
    if (m_fm != 0 && e > -1) e = -1;
    return e;
  endfunction

  function automatic int exp_pend();
    if (pend_kind == 2'd1) return -1;
    if (pend_kind == 2'd2) return -2;
    if (pend_kind == 2'd3) return -3;
    return int'(pend_prio);
  endfunction

  function automatic int exp_rd();
    if (rd_sel == 2'd0) return m_gm;
    if (rd_sel == 2'd1) return m_fm;
    if (rd_sel == 2'd2) return m_base;
    return 0;
  endfunction

  // Reference state update, one step per rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gm = 0; m_fm = 0; m_base = 0;
    end else begin
      automatic bit allow = exp_eff() >= 0;
      if (priv && wr_en && wr_sel == 2'd0) m_gm = int'(wr_data[0]);
      else if (priv && gm_clr) m_gm = 0;
      else if (priv && gm_set) m_gm = 1;
      if (exc_ret && !ret_nmi) m_fm = 0;
      else if (priv && wr_en && wr_sel == 2'd1) begin
        if (!wr_data[0]) m_fm = 0;
        else if (allow) m_fm = 1;
      end
      else if (priv && fm_clr) m_fm = 0;
      else if (priv && fm_set && allow) m_fm = 1;
      if (priv && wr_en && wr_sel == 2'd2) m_base = int'(wr_data) & BMASK;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference.
  task automatic compare_all();
    chk(int'(eff_prio), exp_eff(), "R5 effective level");
    chk(int'(preempt_ok), int'(exp_pend() < exp_eff()), "R8 preempt");
    chk(int'(rd_data), exp_rd(), "R10 read data");
  endtask

  task automatic quiet();
    wr_en = 0; gm_set = 0; gm_clr = 0; fm_set = 0; fm_clr = 0; exc_ret = 0; ret_nmi = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #0.5;
    compare_all();
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = FW'(data);
    cyc(); quiet();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s); #0.1;
      chk(int'(rd_data), 0, "R1 reset read");
    end
    act_prio = EPW'(77); #0.1;
    chk(int'(eff_prio), 77, "R1 eff follows active");

    // R7: unprivileged write and pulse ignored
    priv = 0; rd_sel = 2'd0; gm_set = 1; wr(0, 1);
    chk(int'(rd_data), 0, "R7 unpriv global bit");
    rd_sel = 2'd2; wr(2, 8'hFF);
    chk(int'(rd_data), 0, "R7 unpriv base");

    // R2: global bit boosts to 0
    priv = 1; act_prio = EPW'(IDLE); rd_sel = 2'd0; wr(0, 1);
    chk(int'(eff_prio), 0, "R2 global boost");
    pend_kind = 2'd0; pend_prio = 8'd0; #0.1;
    chk(int'(preempt_ok), 0, "R2 cfg level 0 blocked");
    pend_kind = 2'd1; #0.1;
    chk(int'(preempt_ok), 1, "R9 hard fault passes global mask");

    // R11: clear beats set; write beats pulse
    gm_set = 1; gm_clr = 1; cyc(); quiet();
    chk(int'(rd_data), 0, "R11 clear over set");
    gm_set = 1; wr(0, 0);
    chk(int'(rd_data), 0, "R11 write over pulse");

    // R3: fault set blocked at hard-fault level, unprivileged, then allowed
    rd_sel = 2'd1; act_prio = -EPW'(1); fm_set = 1; cyc(); quiet();
    chk(int'(rd_data), 0, "R3 set ignored in hard fault");
    act_prio = -EPW'(2); wr(1, 1);
    chk(int'(rd_data), 0, "R3 write ignored in NMI");
    act_prio = EPW'(IDLE); priv = 0; fm_set = 1; cyc(); quiet(); priv = 1;
    chk(int'(rd_data), 0, "R3 unpriv set ignored");
    fm_set = 1; cyc(); quiet();
    chk(int'(rd_data), 1, "R3 set accepted");
    chk(int'(eff_prio), -1, "R3 fault boost");
    pend_kind = 2'd1; #0.1;
    chk(int'(preempt_ok), 0, "R9 hard fault blocked by fault bit");
    pend_kind = 2'd2; #0.1;
    chk(int'(preempt_ok), 1, "R9 NMI passes fault bit");

    // R4: NMI return keeps, other return clears even against a set
    exc_ret = 1; ret_nmi = 1; cyc(); quiet();
    chk(int'(rd_data), 1, "R4 NMI return keeps");
    exc_ret = 1; fm_set = 1; cyc(); quiet();
    chk(int'(rd_data), 0, "R4 return beats set");

    // R6 / R5: base threshold
    rd_sel = 2'd2; wr(2, 8'hFF);
    chk(int'(rd_data), BMASK, "R6 low bits dropped");
    wr(2, 8'h4F); act_prio = EPW'(8'h80); #0.1;
    chk(int'(eff_prio), 8'h40, "R5 base lowers level");
    pend_kind = 2'd0; pend_prio = 8'h40; #0.1;
    chk(int'(preempt_ok), 0, "R8 equal level blocked");
    pend_prio = 8'h3F; #0.1;
    chk(int'(preempt_ok), 1, "R8 strictly lower passes");
    act_prio = EPW'(8'h20); #0.1;
    chk(int'(eff_prio), 8'h20, "R5 active more urgent than base");
    wr(2, 0); act_prio = EPW'(8'h90); #0.1;
    chk(int'(eff_prio), 8'h90, "R5 zero base no effect");
    rd_sel = 2'd3; #0.1;
    chk(int'(rd_data), 0, "R10 unused select reads zero");

    // Mixed traffic: returns, sets and writes collide freely.
    for (int i = 0; i < 4000; i++) begin
      automatic int r = int'($urandom % 4);
      priv = ($urandom % 4) != 0;
      wr_en = ($urandom % 4) == 0;
      wr_sel = 2'($urandom); wr_data = FW'($urandom);
      gm_set = ($urandom % 6) == 0; gm_clr = ($urandom % 6) == 0;
      fm_set = ($urandom % 4) == 0; fm_clr = ($urandom % 8) == 0;
      exc_ret = ($urandom % 6) == 0; ret_nmi = 1'($urandom);
      act_prio = (r == 0) ? EPW'(IDLE) : (r == 1) ? EPW'($urandom % IDLE)
               : (r == 2) ? -EPW'(1) : -EPW'(2);
      pend_kind = 2'($urandom); pend_prio = FW'($urandom);
      rd_sel = 2'($urandom);
      cyc();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule